// File: doc/BRIEF.md
# Pipelined Cartesian-to-Polar Converter

This block turns a stream of Cartesian samples (X, Y) into polar form: a 16-bit magnitude and a 12-bit signed phase angle. It accepts one sample per clock. A sample first has its sign removed and is folded into the first quadrant. It then passes through a chain of shift-and-add vectoring stages, one per register stage, and leaves through an output register. That register removes the constant vectoring gain, applies the selected magnitude weighting and saturates on overflow. The latency is fixed at 17 rising edges. A valid flag travels with each sample.

Each input word has its own load strobe, active low, so X and Y can be refreshed independently. A format bit travels with each sample. It says whether both words are two's complement or sign-magnitude. The magnitude and phase ports each have an active-low output enable, so the block can share a result bus. The pipeline has no back-pressure. A result appears exactly 17 edges after its sample is captured, and the consumer must take it in that cycle. There is no ready input, and nothing stalls or drops.

Top module: `cart_polar_conv`

## Requirements
- R1: On a rising edge the X word loads from `x_i` only when `x_ld_n` is low, and the Y word loads from `y_i` only when `y_ld_n` is low. A word whose strobe is high keeps its previous value.
- R2: `fmt_sm_i` loads on any edge where at least one strobe is low and sets how both held words are read. 0 means two's complement. 1 means sign-magnitude, with bit 15 the sign and bits 14..0 the magnitude. In two's complement 0x8000 is not a legal input.
- R3: Sign-magnitude 0x8000 (negative zero) is read as zero. An input of (0, 0) gives magnitude 0 and phase 0.
- R4: The internal magnitude word is 8·sqrt(X²+Y²). The magnitude output is that word shifted right by 0, 1, 2 or 3 bits for scale codes 0, 1, 2 and 3. The result is within (24>>code)+2 LSB of the floor of the exact value.
- R5: The phase output is round(atan2(Y,X)·2048/π) modulo 4096, within ±2 LSB. Bit 11 has weight π, so 0x400 is +π/2, 0xC00 is −π/2, and a negative X with zero Y gives 0x800.
- R6: A sample captured on rising edge n is presented on the outputs just after edge n+16. One new sample is accepted every clock.
- R7: `scale_i` is registered, and a new code changes the magnitude one cycle after the edge that captured it.
- R8: When the shifted magnitude exceeds 0xFFFF, `ovf_o` is 1 and the magnitude reads 0xFFFF. Otherwise `ovf_o` is 0.
- R9: When `mag_oe_n` is high the magnitude port is high impedance, and when `ph_oe_n` is high the phase port is high impedance. Each enable acts at once and only on its own port.
- R10: While `rst_n` is low, magnitude, phase, `ovf_o` and `res_valid_o` are all 0.
- R11: `res_valid_o` is 1 exactly for the results whose capture edge had at least one strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_ld_n | input | 1 | X word load strobe, active low |
| y_ld_n | input | 1 | Y word load strobe, active low |
| x_i | input | 16 | X sample |
| y_i | input | 16 | Y sample |
| fmt_sm_i | input | 1 | Sample format: 0 two's complement, 1 sign-magnitude |
| scale_i | input | 2 | Magnitude weighting code (right shift 0..3) |
| mag_oe_n | input | 1 | Magnitude port drive enable, active low |
| ph_oe_n | input | 1 | Phase port drive enable, active low |
| mag_o | output | 16 | Magnitude result, tri-state |
| ph_o | output | 12 | Phase result, signed, MSB weight π, tri-state |
| ovf_o | output | 1 | Magnitude does not fit the selected weighting |
| res_valid_o | output | 1 | Result on the outputs came from a loaded sample |

## Verification
The embedded properties check, on every cycle, the invariants that hold whatever the data: the X path of every stage stays non-negative, and the folded angle stays inside the first quadrant. They also check that the residual Y converges, that an overflow always shows a saturated magnitude, that a zero input leaves zero phase, that negative zero decodes to zero, and that a word with its strobe high holds. Only the bench scenarios can show the numerical accuracy of magnitude and phase in all four quadrants and both formats. The same holds for the exact 17-edge latency under back-to-back streaming, the one-cycle lag of the scale code, and the tri-state release of each port.

// File: rtl/cpol_pkg.sv
package cpol_pkg;

  parameter int DW    = 16;              // input / magnitude width
  parameter int GUARD = 3;               // fractional guard bits in the vector path
  parameter int XW    = DW + GUARD + 2;  // signed vector path width (growth + sign)
  parameter int AW    = 16;              // angle accumulator, 2^AW = one turn
  parameter int PW    = 12;              // phase output width
  parameter int NSTG  = 14;              // vectoring stages
  parameter int SCW   = 2;               // scale code width
  parameter int KW    = 16;              // gain constant fraction bits
  parameter int KGAIN = 39797;           // round(2^KW / vectoring gain) for NSTG >= 10

  typedef struct packed {
    logic                 v;     // sample was loaded
    logic                 sx;    // X negative (non-zero)
    logic                 sy;    // Y negative (non-zero)
    logic                 zero;  // both components zero
    logic signed [XW-1:0] x;
    logic signed [XW-1:0] y;
    logic signed [AW-1:0] z;
  } cpol_lane_t;

  // arctan(2^-i) in units of one turn / 2^16, rescaled to AW bits
  function automatic logic [AW-1:0] atan_step(input int i);
    int base;
    case (i)
      0:  base = 8192;
      1:  base = 4836;
      2:  base = 2555;
      3:  base = 1297;
      4:  base = 651;
      5:  base = 326;
      6:  base = 163;
      7:  base = 81;
      8:  base = 41;
      9:  base = 20;
      10: base = 10;
      11: base = 5;
      12: base = 3;
      13: base = 1;
      14: base = 1;
      default: base = 0;
    endcase
    if (AW >= 16) atan_step = AW'(base << (AW - 16));
    else          atan_step = AW'(base >> (16 - AW));
  endfunction

endpackage

// File: rtl/cpol_front.sv
module cpol_front
  import cpol_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_ld_n,
  input  logic          y_ld_n,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          fmt_sm_i,
  output cpol_lane_t    lane_o
);

  localparam int PADW = XW - DW - GUARD;

  logic [DW-1:0] x_r, y_r;
  logic          fmt_r, v_r;

  // input capture, each word with its own strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_r   <= '0;
      y_r   <= '0;
      fmt_r <= 1'b0;
      v_r   <= 1'b0;
    end else begin
      if (!x_ld_n) x_r <= x_i;
      if (!y_ld_n) y_r <= y_i;
      if (!x_ld_n || !y_ld_n) fmt_r <= fmt_sm_i;
      v_r <= !x_ld_n || !y_ld_n;
    end
  end

  // split a word into sign and magnitude under the captured format
  function automatic logic [DW:0] split(input logic [DW-1:0] w, input logic sm);
    logic [DW-1:0] m;
    if (sm)         m = {1'b0, w[DW-2:0]};
    else if (w[DW-1]) m = ~w + 1'b1;
    else            m = w;
    split = {w[DW-1], m};
  endfunction

  logic [DW:0] xs, ys;
  always_comb begin
    xs = split(x_r, fmt_r);
    ys = split(y_r, fmt_r);
  end

  // quadrant fold: magnitudes enter the vectoring chain, signs ride along
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_o <= '0;
    end else begin
      lane_o.v    <= v_r;
      lane_o.sx   <= xs[DW] && (xs[DW-1:0] != '0);
      lane_o.sy   <= ys[DW] && (ys[DW-1:0] != '0);
      lane_o.zero <= (xs[DW-1:0] == '0) && (ys[DW-1:0] == '0);
      lane_o.x    <= $signed({{PADW{1'b0}}, xs[DW-1:0], {GUARD{1'b0}}});
      lane_o.y    <= $signed({{PADW{1'b0}}, ys[DW-1:0], {GUARD{1'b0}}});
      lane_o.z    <= '0;
    end
  end

  a_r1_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    x_ld_n |=> (x_r == $past(x_r)));

  a_r1_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    y_ld_n |=> (y_r == $past(y_r)));

  a_r3_negzero: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_r && x_r == {1'b1, {(DW-1){1'b0}}}) |=> (lane_o.x == '0 && !lane_o.sx));

endmodule

// File: rtl/cpol_iter.sv
module cpol_iter
  import cpol_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cpol_lane_t d,
  output cpol_lane_t q
);

  localparam logic signed [AW-1:0] STEP = $signed(atan_step(IDX));

  logic signed [XW-1:0] xsh, ysh;
  always_comb begin
    xsh = $signed(d.x) >>> IDX;
    ysh = $signed(d.y) >>> IDX;
  end

  // one vectoring micro-rotation: drive Y toward zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q.v    <= d.v;
      q.sx   <= d.sx;
      q.sy   <= d.sy;
      q.zero <= d.zero;
      if (!d.y[XW-1]) begin
        q.x <= d.x + ysh;
        q.y <= d.y - xsh;
        q.z <= d.z + STEP;
      end else begin
        q.x <= d.x - ysh;
        q.y <= d.y + xsh;
        q.z <= d.z - STEP;
      end
    end
  end

  a_r4_x_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    !q.x[XW-1]);

endmodule

// File: rtl/cpol_back.sv
module cpol_back
  import cpol_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  cpol_lane_t     lane_i,
  input  logic [SCW-1:0] scale_i,
  output logic [DW-1:0]  mag_q,
  output logic [PW-1:0]  ph_q,
  output logic           ovf_q,
  output logic           vld_q
);

  localparam int PW_RND = AW - PW - 1;
  localparam logic [XW+KW-1:0] KMUL = (XW+KW)'(KGAIN);
  localparam logic [XW+KW-1:0] KRND = (XW+KW)'(1) << (KW - 1);
  localparam logic [AW-1:0]    HALF = AW'(1) << (AW - 1);
  localparam logic [AW-1:0]    PRND = AW'(1) << PW_RND;
  localparam int               QUART  = 1 << (AW - 2);
  localparam int               MARGIN = 1 << (AW - 4);

  logic [SCW-1:0]    scale_r;
  logic [XW+KW-1:0]  prod;
  logic [XW-1:0]     wmag, wsh;
  logic              ovf_c;
  logic [DW-1:0]     mag_c;
  logic [AW-1:0]     za, ang, angr;

  // gain removal, weighting and saturation
  always_comb begin
    prod  = (XW+KW)'($unsigned(lane_i.x)) * KMUL;
    wmag  = XW'((prod + KRND) >> KW);
    wsh   = wmag >> scale_r;
    ovf_c = |wsh[XW-1:DW];
    mag_c = ovf_c ? '1 : wsh[DW-1:0];
  end

  // quadrant unfold of the first-quadrant angle
  always_comb begin
    za = lane_i.z;
    case ({lane_i.sx, lane_i.sy})
      2'b00:   ang = za;
      2'b10:   ang = HALF - za;
      2'b11:   ang = za - HALF;
      default: ang = '0 - za;
    endcase
    angr = ang + PRND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_r <= '0;
      mag_q   <= '0;
      ph_q    <= '0;
      ovf_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      scale_r <= scale_i;
      mag_q   <= mag_c;
      ph_q    <= lane_i.zero ? '0 : angr[AW-1:AW-PW];
      ovf_q   <= ovf_c;
      vld_q   <= lane_i.v;
    end
  end

  logic [XW-1:0] yabs;
  always_comb yabs = lane_i.y[XW-1] ? XW'(-lane_i.y) : XW'(lane_i.y);

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (mag_q == '1));

  a_r3_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
    lane_i.zero |=> (ph_q == '0 && mag_q == '0 && !ovf_q));

  a_r5_first_quadrant: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_i.zero |-> (int'(lane_i.z) >= -MARGIN && int'(lane_i.z) <= QUART + MARGIN));

  a_r4_y_converged: assert property (@(posedge clk) disable iff (!rst_n)
    yabs <= (($unsigned(lane_i.x) >> 10) + XW'(32)));

endmodule

// File: rtl/cart_polar_conv.sv
module cart_polar_conv
  import cpol_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           x_ld_n,
  input  logic           y_ld_n,
  input  logic [DW-1:0]  x_i,
  input  logic [DW-1:0]  y_i,
  input  logic           fmt_sm_i,
  input  logic [SCW-1:0] scale_i,
  input  logic           mag_oe_n,
  input  logic           ph_oe_n,
  output wire  [DW-1:0]  mag_o,
  output wire  [PW-1:0]  ph_o,
  output logic           ovf_o,
  output logic           res_valid_o
);

  cpol_lane_t    lane [NSTG+1];
  logic [DW-1:0] mag_q;
  logic [PW-1:0] ph_q;

  cpol_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .x_ld_n   (x_ld_n),
    .y_ld_n   (y_ld_n),
    .x_i      (x_i),
    .y_i      (y_i),
    .fmt_sm_i (fmt_sm_i),
    .lane_o   (lane[0])
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    cpol_iter #(.IDX(g)) u_iter (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lane[g]),
      .q     (lane[g+1])
    );
  end

  cpol_back u_back (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_i  (lane[NSTG]),
    .scale_i (scale_i),
    .mag_q   (mag_q),
    .ph_q    (ph_q),
    .ovf_q   (ovf_o),
    .vld_q   (res_valid_o)
  );

  assign mag_o = mag_oe_n ? {DW{1'bz}} : mag_q;
  assign ph_o  = ph_oe_n  ? {PW{1'bz}} : ph_q;

endmodule

// File: tb/cart_polar_conv_test.sv
module cart_polar_conv_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        x_ld_n, y_ld_n, fmt;
  logic [15:0] x, y;
  logic [1:0]  sc;
  logic        mag_oe_n, ph_oe_n;
  tri1  [15:0] mag_w;
  tri1  [11:0] ph_w;
  logic        ovf, vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cart_polar_conv uut (
    .clk(clk), .rst_n(rst_n), .x_ld_n(x_ld_n), .y_ld_n(y_ld_n),
    .x_i(x), .y_i(y), .fmt_sm_i(fmt), .scale_i(sc),
    .mag_oe_n(mag_oe_n), .ph_oe_n(ph_oe_n),
    .mag_o(mag_w), .ph_o(ph_w), .ovf_o(ovf), .res_valid_o(vld)
  );

  // {fmt, x, y, scale}
  localparam int NV = 15;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 16'd3000, 16'd4000, 2'd3},
    {1'b0, 16'hF448, 16'd4000, 2'd3},
    {1'b0, 16'hF448, 16'hF060, 2'd3},
    {1'b0, 16'd3000, 16'hF060, 2'd2},
    {1'b1, 16'h8BB8, 16'h0FA0, 2'd3},   // R2 sign-magnitude
    {1'b1, 16'h0BB8, 16'h8FA0, 2'd1},   // R2 sign-magnitude
    {1'b0, 16'h7FFF, 16'h7FFF, 2'd3},
    {1'b0, 16'h8001, 16'h0000, 2'd3},   // R5 -> 0x800
    {1'b0, 16'h0000, 16'h8001, 2'd3},   // R5 -> 0xC00
    {1'b1, 16'h8000, 16'h1234, 2'd3},   // R3 negative zero X, R5 -> 0x400
    {1'b0, 16'd1000, 16'h0000, 2'd0},
    {1'b0, 16'd12345, 16'hE57B, 2'd1},
    {1'b1, 16'hFFFF, 16'h7FFF, 2'd3},
    {1'b0, 16'h0000, 16'h0000, 2'd0},   // R3 zero
    {1'b1, 16'h8000, 16'h8000, 2'd2}    // R3 double negative zero
  };

  function automatic real sval(input logic f, input logic [15:0] v);
    if (f) return v[15] ? -real'(v[14:0]) : real'(v[14:0]);
    return real'($signed(v));
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input int tol, input bit wrap);
    int diff;
    diff = act - exp;
    if (wrap) diff = ((diff % 4096) + 4096 + 2048) % 4096 - 2048;
    if (diff < 0) diff = -diff;
    checks++;
    if (diff > tol) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic drive(input logic [34:0] v);
    fmt = v[34];
    x   = v[33:18];
    y   = v[17:2];
    sc  = v[1:0];
  endtask

  task automatic expect_vec(input logic [34:0] v, input string tag);
    real xr, yr, w, e, p;
    int  em, eph, s;
    bit  eovf;
    xr = sval(v[34], v[33:18]);
    yr = sval(v[34], v[17:2]);
    s  = int'(v[1:0]);
    w  = $sqrt(xr * xr + yr * yr) * 8.0;
    e  = $floor(w / (2.0 ** s));
    eovf = (e > 65535.0);
    em = eovf ? 65535 : int'(e);
    if (xr == 0.0 && yr == 0.0) eph = 0;
    else begin
      p   = $atan2(yr, xr) * 2048.0 / 3.14159265358979;
      eph = int'(p) & 4095;
    end
    chk({tag, " R4 magnitude"}, int'(mag_w), em, (24 >> s) + 2, 1'b0);
    chk({tag, " R5 phase"}, int'(ph_w), eph, 2, 1'b1);
    chk({tag, " R8 overflow"}, int'(ovf), int'(eovf), 0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; x_ld_n = 1'b1; y_ld_n = 1'b1;
    x = '0; y = '0; fmt = 1'b0; sc = '0;
    mag_oe_n = 1'b0; ph_oe_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset magnitude", int'(mag_w), 0, 0, 1'b0);
    chk("R10 reset phase", int'(ph_w), 0, 0, 1'b0);
    chk("R10 reset overflow", int'(ovf), 0, 0, 1'b0);
    chk("R10 reset valid", int'(vld), 0, 0, 1'b0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R8 across quadrants and formats
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      x_ld_n = 1'b0; y_ld_n = 1'b0;
      repeat (18) @(negedge clk);
      expect_vec(VEC[i], $sformatf("vec %0d", i));
      chk("R11 valid after load", int'(vld), 1, 0, 1'b0);
    end

    // R1: X strobe high holds X while Y keeps loading, then the reverse
    drive({1'b0, 16'd3000, 16'd4000, 2'd3});
    repeat (18) @(negedge clk);
    x_ld_n = 1'b1; x = 16'd100;
    repeat (18) @(negedge clk);
    expect_vec({1'b0, 16'd3000, 16'd4000, 2'd3}, "R1 x held");
    x_ld_n = 1'b0; y_ld_n = 1'b1; x = 16'd0; y = 16'd77;
    repeat (18) @(negedge clk);
    expect_vec({1'b0, 16'd0, 16'd4000, 2'd3}, "R1 y held");
    y_ld_n = 1'b0;

    // R8 overflow corners
    drive({1'b0, 16'h7FFF, 16'h7FFF, 2'd0});
    repeat (18) @(negedge clk);
    expect_vec({1'b0, 16'h7FFF, 16'h7FFF, 2'd0}, "R8 full scale code0");
    sc = 2'd2;
    repeat (3) @(negedge clk);
    expect_vec({1'b0, 16'h7FFF, 16'h7FFF, 2'd2}, "R8 full scale code2");
    drive({1'b0, 16'd9000, 16'd0, 2'd0});
    repeat (18) @(negedge clk);
    expect_vec({1'b0, 16'd9000, 16'd0, 2'd0}, "R8 9000 code0");

    // R9 output enables
    drive({1'b0, 16'h7FFF, 16'h7FFF, 2'd3});
    repeat (18) @(negedge clk);
    mag_oe_n = 1'b1;
    #1;
    chk("R9 magnitude released", int'(mag_w), 16'hFFFF, 0, 1'b0);
    chk("R9 phase still driven", int'(ph_w), 12'h200, 2, 1'b0);
    mag_oe_n = 1'b0; ph_oe_n = 1'b1;
    #1;
    chk("R9 phase released", int'(ph_w), 12'hFFF, 0, 1'b0);
    chk("R9 magnitude still driven", int'(mag_w), 46340, 5, 1'b0);
    ph_oe_n = 1'b0;

    // R7 scale lag
    drive({1'b0, 16'd1000, 16'd0, 2'd3});
    repeat (18) @(negedge clk);
    sc = 2'd0;
    @(negedge clk);
    chk("R7 old scale one cycle", int'(mag_w), 1000, 5, 1'b0);
    @(negedge clk);
    chk("R7 new scale applied", int'(mag_w), 8000, 26, 1'b0);

    // R6 R11 back-to-back stream
    x_ld_n = 1'b1; y_ld_n = 1'b1; sc = 2'd3;
    repeat (20) @(negedge clk);
    for (int c = 0; c < 27; c++) begin
      if (c >= 17 && c < 25)
        expect_vec({VEC[c-17][34:2], 2'd3}, $sformatf("R6 stream %0d", c - 17));
      chk($sformatf("R11 stream valid at %0d", c), int'(vld), (c >= 17 && c < 25) ? 1 : 0, 0, 1'b0);
      if (c < 8) begin
        drive({VEC[c][34:2], 2'd3});
        x_ld_n = 1'b0; y_ld_n = 1'b0;
      end else begin
        x_ld_n = 1'b1; y_ld_n = 1'b1;
      end
      @(negedge clk);
    end

    finish_run();
  end

endmodule